// File: doc/BRIEF.md
# Eight-Register Bus Datapath

This block holds eight general registers and carries out one register-transfer micro-operation per clock. A fully decomposed control word comes in on every cycle. It names the register that drives operand bus A and the register that drives operand bus B, or it substitutes a constant for B. It picks an arithmetic or logic operation and a shift operation, and it chooses which of their results reaches the write-back bus, or routes external data onto that bus instead. It also names the destination register and gates the write with a load enable.

Both operand buses leave the block as ports. Bus A serves as a memory address and bus B as write data. Four status flags describe the current arithmetic/logic result. A sequencer outside the block supplies the control words and receives the flags. A transfer such as "first register gets second plus third" takes a single clock: the reads are combinational, and the write lands on the next rising edge.

Top module: `regfile_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all eight registers to zero.
- R2: `addr_out` always shows the register picked by `a_sel`. While `const_sel` is 0, `data_out` shows the register picked by `b_sel`.
- R3: While `const_sel` is 1, `data_out` carries `const_in`, and that value is the B operand of every operation.
- R4: With `load_en` high, the write-back value is stored at the rising edge into the register named by `dest_sel`. No other register changes.
- R5: With `load_en` low, no register changes, whatever the other control inputs are.
- R6: The write-back value is the function result when `md_sel`=0 and `data_in` when `md_sel`=1.
- R7: The function result is the arithmetic/logic output when `mf_sel`=0 and the shifter output when `mf_sel`=1.
- R8: Arithmetic `g_code` values are: 0 = A, 1 = A+1, 2 = A+B, 3 = A+B+1, 4 = one's complement of B, 5 = two's complement of B, 6 = A minus B (formed as A + ~B + 1), 7 = A-1. All results wrap modulo 2^W.
- R9: Logic `g_code` values work bitwise: 8 = A AND B, 9 = A OR B, 10 = A XOR B, 11 = NOT A. Codes 12 to 15 pass A.
- R10: The shifter acts on bus B. `h_code` 1 shifts right one place with a 0 entering the MSB. 2 shifts left one place with a 0 entering the LSB. 0 and 3 pass B unchanged. For example, 0x71 becomes 0x38 (right) and 0xE2 (left).
- R11: `flag_c` is the carry out of the adder and `flag_v` is two's-complement overflow of the arithmetic codes. Both are 0 for logic codes (8 to 15).
- R12: `flag_n` equals the MSB of the arithmetic/logic output. `flag_z` is 1 exactly when every bit of that output is 0.
- R13: A register may be both a source and the destination of one micro-operation. The old value is used, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 3 | Register driving bus A |
| b_sel | input | 3 | Register driving bus B |
| dest_sel | input | 3 | Destination register |
| const_sel | input | 1 | 1 puts const_in on bus B |
| const_in | input | 8 | Constant operand |
| g_code | input | 4 | Arithmetic/logic operation |
| h_code | input | 2 | Shift operation |
| mf_sel | input | 1 | 0 ALU, 1 shifter to function result |
| md_sel | input | 1 | 0 function result, 1 data_in to write-back |
| load_en | input | 1 | Write enable for destination register |
| data_in | input | 8 | External write-back data |
| addr_out | output | 8 | Bus A |
| data_out | output | 8 | Bus B |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
All state lives in the eight registers. Selecting a register onto bus A makes any corruption visible on `addr_out` in the same cycle, so a stray write, a missed write or a write to the wrong destination shows up one clock after the faulty edge. The model in the bench therefore reads back every register after each scenario. A wrong operation decode leaves the registers intact but shows at once on the flags, and on the next read-back of the destination.

// File: rtl/regfile_datapath.sv
module regfile_datapath #(
  parameter int W    = 8,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] a_sel,
  input  logic [SW-1:0] b_sel,
  input  logic [SW-1:0] dest_sel,
  input  logic          const_sel,
  input  logic [W-1:0]  const_in,
  input  logic [3:0]    g_code,
  input  logic [1:0]    h_code,
  input  logic          mf_sel,
  input  logic          md_sel,
  input  logic          load_en,
  input  logic [W-1:0]  data_in,
  output logic [W-1:0]  addr_out,
  output logic [W-1:0]  data_out,
  output logic          flag_v,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z
);

  logic [W-1:0] regs [NREG];
  logic [W-1:0] bus_a, bus_b;
  logic [W-1:0] opx, opy, lres, alu_y, shf, func, wb;
  logic         cin, is_logic;
  logic [W:0]   sum;

  assign bus_a = regs[a_sel];
  assign bus_b = const_sel ? const_in : regs[b_sel];

  always_comb begin
    opx  = bus_a;
    opy  = '0;
    cin  = 1'b0;
    lres = bus_a;
    is_logic = g_code[3];
    unique case (g_code)
      4'd1: cin = 1'b1;
      4'd2: opy = bus_b;
      4'd3: begin opy = bus_b; cin = 1'b1; end
      4'd4: begin opx = '0; opy = ~bus_b; end
      4'd5: begin opx = '0; opy = ~bus_b; cin = 1'b1; end
      4'd6: begin opy = ~bus_b; cin = 1'b1; end
      4'd7: opy = '1;
      4'd8: lres = bus_a & bus_b;
      4'd9: lres = bus_a | bus_b;
      4'd10: lres = bus_a ^ bus_b;
      4'd11: lres = ~bus_a;
      default: ;
    endcase
  end

  assign sum   = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, cin};
  assign alu_y = is_logic ? lres : sum[W-1:0];

  assign flag_c = !is_logic && sum[W];
  assign flag_v = !is_logic && (opx[W-1] == opy[W-1]) && (sum[W-1] != opx[W-1]);
  assign flag_n = alu_y[W-1];
  assign flag_z = (alu_y == '0);

  always_comb begin
    unique case (h_code)
      2'd1:    shf = {1'b0, bus_b[W-1:1]};
      2'd2:    shf = {bus_b[W-2:0], 1'b0};
      default: shf = bus_b;
    endcase
  end

  assign func = mf_sel ? shf : alu_y;
  assign wb   = md_sel ? data_in : func;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (load_en) begin
      regs[dest_sel] <= wb;
    end
  end

  assign addr_out = bus_a;
  assign data_out = bus_b;

endmodule

// File: rtl/regfile_datapath_chk.sv
module regfile_datapath_chk #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] a_sel,
  input logic [SW-1:0] dest_sel,
  input logic          const_sel,
  input logic [W-1:0]  const_in,
  input logic [3:0]    g_code,
  input logic          md_sel,
  input logic          load_en,
  input logic [W-1:0]  data_in,
  input logic [W-1:0]  addr_out,
  input logic [W-1:0]  data_out,
  input logic          flag_v,
  input logic          flag_c,
  input logic [W-1:0]  wb_bus
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> addr_out == '0);

  a_r3_const_on_b: assert property (@(posedge clk) disable iff (rst)
    const_sel |-> data_out == const_in);

  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (a_sel != $past(dest_sel)) || (addr_out == $past(wb_bus)));

  a_r5_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (a_sel != $past(a_sel)) || $stable(addr_out));

  a_r6_external_data: assert property (@(posedge clk) disable iff (rst)
    (load_en && md_sel) |=> (a_sel != $past(dest_sel)) || (addr_out == $past(data_in)));

  a_r11_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    g_code[3] |-> (!flag_c && !flag_v));

endmodule

bind regfile_datapath regfile_datapath_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .a_sel(a_sel), .dest_sel(dest_sel),
  .const_sel(const_sel), .const_in(const_in), .g_code(g_code),
  .md_sel(md_sel), .load_en(load_en), .data_in(data_in),
  .addr_out(addr_out), .data_out(data_out), .flag_v(flag_v),
  .flag_c(flag_c), .wb_bus(wb)
);

// File: tb/regfile_datapath_bench.sv
`timescale 1ns/1ps
module regfile_datapath_bench;
  localparam int W = 8;
  localparam int N = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, const_sel, mf_sel, md_sel, load_en;
  logic [2:0] a_sel, b_sel, dest_sel;
  logic [W-1:0] const_in, data_in, addr_out, data_out;
  logic [3:0] g_code;
  logic [1:0] h_code;
  logic flag_v, flag_c, flag_n, flag_z;

  regfile_datapath u_regfile_datapath (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [W-1:0] mdl [N];

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_alu(int g, logic [7:0] a, logic [7:0] b);
    int ua = a, ub = b, sa = $signed(a), sb = $signed(b), u = 0, s = 0;
    logic [7:0] y;
    logic c, v;
    if (g >= 8) begin
      case (g)
        8: y = a & b;
        9: y = a | b;
        10: y = a ^ b;
        11: y = ~a;
        default: y = a;
      endcase
      return {2'b00, y};
    end
    case (g)
      0: begin u = ua; s = sa; end
      1: begin u = ua + 1; s = sa + 1; end
      2: begin u = ua + ub; s = sa + sb; end
      3: begin u = ua + ub + 1; s = sa + sb + 1; end
      4: begin u = 255 - ub; s = -sb - 1; end
      5: begin u = 256 - ub; s = -sb; end
      6: begin u = ua + 256 - ub; s = sa - sb; end
      default: begin u = ua + 255; s = sa - 1; end
    endcase
    y = u[7:0];
    c = (u > 255);
    v = (s > 127) || (s < -128);
    return {v, c, y};
  endfunction

  function automatic logic [7:0] exp_shift(int h, logic [7:0] b);
    if (h == 1) return b >> 1;
    if (h == 2) return b << 1;
    return b;
  endfunction

  task automatic check_reg(int r, string req);
    load_en = 1'b0;
    a_sel = r[2:0];
    #1;
    chk(req, $sformatf("reg%0d", r), addr_out, mdl[r]);
  endtask

  task automatic check_all(string req);
    for (int r = 0; r < N; r++) check_reg(r, req);
  endtask

  task automatic run(int a, int b, bit cs, logic [7:0] cv, int g, int h,
                     bit mf, bit md, int d, bit ld, logic [7:0] din, string req);
    logic [7:0] av, bv, sh, wbv;
    logic [9:0] res;
    a_sel = a[2:0]; b_sel = b[2:0]; const_sel = cs; const_in = cv;
    g_code = g[3:0]; h_code = h[1:0]; mf_sel = mf; md_sel = md;
    dest_sel = d[2:0]; load_en = ld; data_in = din;
    #1;
    av = mdl[a];
    bv = cs ? cv : mdl[b];
    res = exp_alu(g, av, bv);
    sh = exp_shift(h, bv);
    wbv = md ? din : (mf ? sh : res[7:0]);
    chk("R2", "bus A", addr_out, av);
    chk(cs ? "R3" : "R2", "bus B", data_out, bv);
    chk("R11", "carry", {7'b0, flag_c}, {7'b0, res[8]});
    chk("R11", "overflow", {7'b0, flag_v}, {7'b0, res[9]});
    chk("R12", "negative", {7'b0, flag_n}, {7'b0, res[7]});
    chk("R12", "zero", {7'b0, flag_z}, {7'b0, res[7:0] == 8'h00});
    @(posedge clk);
    if (ld) mdl[d] = wbv;
    @(negedge clk);
    load_en = 1'b0;
    check_reg(d, req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < N; r++) mdl[r] = '0;
    check_all("R1");
  endtask

  task automatic t_load_external();
    logic [7:0] vals [N] = '{8'h12, 8'h34, 8'h56, 8'h7F, 8'h01, 8'hFF, 8'h80, 8'h71};
    for (int r = 0; r < N; r++) run(0, 0, 0, 0, 2, 0, 0, 1, r, 1, vals[r], "R6");
    check_all("R4");
  endtask

  task automatic t_transfer();
    run(2, 3, 0, 0, 2, 0, 0, 0, 1, 1, 8'h00, "R8");
    check_all("R4");
  endtask

  task automatic t_arith();
    for (int g = 0; g < 8; g++) run(3, 4, 0, 0, g, 0, 0, 0, 0, 1, 8'h00, "R8");
    for (int g = 0; g < 8; g++) run(6, 5, 0, 0, g, 0, 0, 0, 0, 1, 8'h00, "R8");
    run(5, 4, 0, 0, 2, 0, 0, 0, 0, 1, 8'h00, "R11");
    run(6, 6, 0, 0, 6, 0, 0, 0, 0, 1, 8'h00, "R12");
    run(6, 6, 0, 0, 5, 0, 0, 0, 2, 1, 8'h00, "R11");
  endtask

  task automatic t_logic();
    for (int g = 8; g < 16; g++) run(7, 5, 0, 0, g, 0, 0, 0, 0, 1, 8'h00, "R9");
    run(7, 7, 0, 0, 10, 0, 0, 0, 0, 1, 8'h00, "R12");
  endtask

  task automatic t_shift();
    run(0, 7, 0, 0, 0, 1, 1, 0, 3, 1, 8'h00, "R10");
    chk("R10", "shift right", mdl[3], 8'h38);
    run(0, 7, 0, 0, 0, 2, 1, 0, 3, 1, 8'h00, "R10");
    chk("R10", "shift left", mdl[3], 8'hE2);
    run(0, 6, 0, 0, 9, 0, 1, 0, 3, 1, 8'h00, "R7");
    run(0, 6, 0, 0, 9, 3, 1, 0, 3, 1, 8'h00, "R7");
  endtask

  task automatic t_const();
    run(1, 0, 1, 8'h5A, 2, 0, 0, 0, 4, 1, 8'h00, "R3");
    run(1, 0, 1, 8'hC3, 0, 2, 1, 0, 4, 1, 8'h00, "R3");
  endtask

  task automatic t_no_load();
    run(2, 3, 0, 0, 2, 0, 0, 1, 5, 0, 8'hAA, "R5");
    run(2, 3, 0, 0, 3, 1, 1, 0, 6, 0, 8'h00, "R5");
    check_all("R5");
  endtask

  task automatic t_rmw();
    run(3, 3, 0, 0, 1, 0, 0, 0, 3, 1, 8'h00, "R13");
    run(3, 3, 0, 0, 2, 0, 0, 0, 3, 1, 8'h00, "R13");
    check_all("R13");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    rst = 1'b1; const_sel = 0; mf_sel = 0; md_sel = 0; load_en = 0;
    a_sel = 0; b_sel = 0; dest_sel = 0; const_in = 0; data_in = 0;
    g_code = 0; h_code = 0;
    @(negedge clk);
    t_reset();
    t_load_external();
    t_transfer();
    t_arith();
    t_logic();
    t_shift();
    t_const();
    t_no_load();
    t_rmw();
    t_reset();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule